// File: doc/BRIEF.md
# Scan-Register SPI Flash Bridge

This block sits behind a boundary-scan user data register and turns one data-register shift into one complete SPI transaction with a serial flash. The host shifts a self-describing frame through the register: leading idle zeros, a single `1` start marker, a 32-bit bit count sent most significant bit first, and then the outgoing payload bits. While the payload streams in, the bridge drives the flash clock from the scan clock, holds chip select low, and returns each flash output bit on the scan output a fixed two bit positions later. The host appends two extra bits and discards the first two positions of the readback window.

All logic is clocked by the scan clock. Inputs are sampled on its rising edge, and the SPI outputs and the scan output change on its falling edge. This gives SPI mode 0 timing on the flash side and normal scan timing on the host side. Leaving the shift state at any point ends the transaction and returns the bridge to waiting for a marker.

Top module: `jtag_spi_bridge`

## Requirements
- R1: While shifting, TDI bits of value 0 before the start marker are ignored: `cs_n` stays 1 and `sck` produces no pulse.
- R2: The 32 bits after the marker form the SCK cycle count N, first bit most significant. Exactly N SCK pulses follow.
- R3: `cs_n` falls once per frame, before the first SCK rise, and rises only after the last SCK pulse. SCK never pulses while `cs_n` is 1.
- R4: The N TDI bits that follow the count appear on `mosi` in arrival order, so the first bit reaches the flash first. `mosi` changes only while `sck` is low.
- R5: `miso` is sampled on each SCK rise. The bit of SCK cycle j appears on `tdo` at shift position p+2, where p is the position of the TDI bit of cycle j.
- R6: SCK runs at the scan clock rate during a transaction and is held at 0 otherwise.
- R7: A count of zero asserts no chip select and returns the bridge to waiting for a marker.
- R8: When `shift` or `sel` drops, or during `capture` or `update`, `cs_n` is 1 by the next rising scan clock edge and no further SCK pulse follows. A later frame then works normally.
- R9: A frame with payload 0x9F followed by 24 clocks returns the flash's three identification bytes on `tdo`, most significant bit first.
- R10: In reset, `cs_n` is 1 and `sck`, `mosi` and `tdo` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Scan clock; also the source of SCK |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel | input | 1 | User data register selected |
| capture | input | 1 | Capture state of the data register |
| update | input | 1 | Update state of the data register |
| shift | input | 1 | Shift state of the data register |
| tdi | input | 1 | Serial frame input |
| tdo | output | 1 | Serial readback (MISO, delayed by 2) |
| sck | output | 1 | Flash serial clock |
| cs_n | output | 1 | Flash chip select, active low |
| mosi | output | 1 | Data to flash |
| miso | input | 1 | Data from flash |

## Verification
The hardest case to reach is an abort in the middle of a payload. The shift state must drop after exactly k payload bits, with a transaction already running, and then the SCK pulse count and chip-select release must be exact. The bench builds every frame bit by bit with a length limit, so it can cut the shift at a chosen payload bit. It checks that exactly that many pulses occurred and that an identification read then succeeds. A zero-length count and long runs of idle zeros reach the other marker-related corners.

// File: rtl/jtag_spi_bridge.sv
module jtag_spi_bridge #(
  parameter int CNT_W = 32
) (
  input  logic tck,
  input  logic rst_n,
  input  logic sel,
  input  logic capture,
  input  logic update,
  input  logic shift,
  input  logic tdi,
  output logic tdo,
  output logic sck,
  output logic cs_n,
  output logic mosi,
  input  logic miso
);
  localparam int LW = $clog2(CNT_W + 1);

  typedef enum logic [1:0] {S_IDLE, S_LEN, S_XFER} st_t;

  st_t              state;
  logic [LW-1:0]    lcnt;
  logic [CNT_W-1:0] cnt;
  logic             xfer_bit, xfer_act, miso_q, sck_en;

  wire              active  = sel & shift & ~capture & ~update;
  wire [CNT_W-1:0]  len_nxt = {cnt[CNT_W-2:0], tdi};

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      lcnt     <= '0;
      cnt      <= '0;
      xfer_bit <= 1'b0;
      xfer_act <= 1'b0;
      miso_q   <= 1'b0;
    end else begin
      miso_q   <= sck_en & miso;
      xfer_act <= 1'b0;
      if (!active) begin
        state <= S_IDLE;
      end else begin
        case (state)
          S_IDLE: if (tdi) begin
            state <= S_LEN;
            lcnt  <= '0;
            cnt   <= '0;
          end
          S_LEN: begin
            cnt  <= len_nxt;
            lcnt <= lcnt + 1'b1;
            if (lcnt == LW'(CNT_W - 1))
              state <= (len_nxt != '0) ? S_XFER : S_IDLE;
          end
          S_XFER: begin
            if (cnt != '0) begin
              xfer_bit <= tdi;
              xfer_act <= 1'b1;
              cnt      <= cnt - CNT_W'(1);
            end else begin
              state <= S_IDLE;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      cs_n   <= 1'b1;
      sck_en <= 1'b0;
      mosi   <= 1'b0;
      tdo    <= 1'b0;
    end else begin
      cs_n   <= (state != S_XFER);
      sck_en <= xfer_act;
      mosi   <= xfer_bit;
      tdo    <= miso_q;
    end
  end

  assign sck = tck & sck_en;

  assert_idle_hold_R1: assert property (@(posedge tck) disable iff (!rst_n)
    (state == S_IDLE && !tdi) |=> (state == S_IDLE));

  assert_count_step_R2: assert property (@(posedge tck) disable iff (!rst_n)
    (state == S_XFER && cnt != '0 && active) |=> (cnt == $past(cnt) - CNT_W'(1)));

  assert_sck_in_cs_R3: assert property (@(posedge tck) disable iff (!rst_n)
    sck_en |-> !cs_n);

  assert_abort_R8: assert property (@(posedge tck) disable iff (!rst_n)
    !active |=> cs_n);

endmodule

// File: tb/jtag_spi_bridge_test.sv
`timescale 1ns/1ps
module jtag_spi_bridge_test;
  localparam logic [23:0] FLASH_ID = 24'h20BA19;
  localparam int NV = 5;
  // {lead zeros[3:0], count[7:0], payload[31:0] MSB first}
  localparam logic [43:0] VEC [NV] = '{
    {4'd3, 8'd32, 32'h9F00_0000},
    {4'd0, 8'd16, 32'h9F00_0000},
    {4'd5, 8'd16, 32'h05A5_0000},
    {4'd1, 8'd8,  32'hC300_0000},
    {4'd2, 8'd24, 32'h9F5A_0000}
  };

  logic tck = 1'b0;
  always #2.5 tck = ~tck;

  logic rst_n = 1'b0, sel = 1'b0, capture = 1'b0, update = 1'b0, shift = 1'b0, tdi = 1'b0;
  logic tdo, sck, cs_n, mosi, miso;

  jtag_spi_bridge uut (.tck(tck), .rst_n(rst_n), .sel(sel), .capture(capture), .update(update),
    .shift(shift), .tdi(tdi), .tdo(tdo), .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso));

  // behavioural flash, SPI mode 0
  logic        fl_clr = 1'b0;
  int          fl_cnt, stray, cs_falls;
  logic [7:0]  fl_cmd;
  logic [63:0] fl_rx;

  always @(posedge sck or posedge fl_clr) begin
    if (fl_clr) begin
      fl_cnt <= 0; stray <= 0; fl_cmd <= '0; fl_rx <= '0;
    end else if (!cs_n) begin
      fl_rx  <= {fl_rx[62:0], mosi};
      fl_cnt <= fl_cnt + 1;
      if (fl_cnt < 8) fl_cmd <= {fl_cmd[6:0], mosi};
    end else begin
      stray <= stray + 1;
    end
  end

  always @(negedge sck or posedge fl_clr) begin
    if (fl_clr) miso <= 1'b0;
    else if (!cs_n && fl_cmd == 8'h9F && fl_cnt >= 8 && fl_cnt < 32) miso <= FLASH_ID[31 - fl_cnt];
    else miso <= 1'b0;
  end

  always @(negedge cs_n or posedge fl_clr) begin
    if (fl_clr) cs_falls <= 0;
    else cs_falls <= cs_falls + 1;
  end

  int checks = 0, errors = 0;
  bit done = 0;
  logic [127:0] fb, cap;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_flash();
    @(negedge tck); #1 fl_clr = 1'b1; #1 fl_clr = 1'b0;
  endtask

  // shift nbits of fb (bit index k = k-th bit on tdi), recording tdo seen at each rising edge
  task automatic run_shift(input int nbits);
    cap = '0;
    @(negedge tck); #1;
    sel = 1'b1; shift = 1'b1; tdi = fb[0];
    for (int k = 0; k < nbits; k++) begin
      @(posedge tck); #1 cap[k] = tdo;
      @(negedge tck); #1 tdi = (k + 1 < nbits) ? fb[k + 1] : 1'b0;
    end
    shift = 1'b0; sel = 1'b0; tdi = 1'b0;
    repeat (3) @(negedge tck);
    #1;
  endtask

  function automatic int build(input int lead, input logic [31:0] n, input logic [31:0] pl);
    int p = 0;
    fb = '0;
    for (int i = 0; i < lead; i++) fb[p++] = 1'b0;
    fb[p++] = 1'b1;
    for (int i = 31; i >= 0; i--) fb[p++] = n[i];
    for (int i = 0; i < int'(n); i++) fb[p++] = pl[31 - i];
    fb[p++] = 1'b0; fb[p++] = 1'b0;
    return p;
  endfunction

  function automatic logic exp_rd(input logic [31:0] pl, input int j);
    return (pl[31:24] == 8'h9F && j >= 8 && j < 32) ? FLASH_ID[31 - j] : 1'b0;
  endfunction

  task automatic full_frame(input int lead, input int n, input logic [31:0] pl, input string tag);
    int total, base;
    logic [63:0] got, exp, sent;
    clear_flash();
    total = build(lead, 32'(n), pl);
    run_shift(total);
    base = lead + 33;
    got = '0; exp = '0; sent = '0;
    for (int j = 0; j < n; j++) begin
      got  = {got[62:0], cap[base + 2 + j]};
      exp  = {exp[62:0], exp_rd(pl, j)};
      sent = {sent[62:0], pl[31 - j]};
    end
    check(cs_falls == 1, {tag, " R3 one cs frame"}, 64'(cs_falls), 64'd1);
    check(stray == 0, {tag, " R3 no sck outside cs"}, 64'(stray), 64'd0);
    check(fl_cnt == n, {tag, " R2 R6 sck pulse count"}, 64'(fl_cnt), 64'(n));
    check(fl_rx == sent, {tag, " R4 mosi order"}, fl_rx, sent);
    check(got == exp, {tag, " R5 tdo readback skew 2"}, got, exp);
    check(cs_n === 1'b1 && sck === 1'b0, {tag, " R3 R6 idle after frame"}, {62'd0, cs_n, sck}, 64'd2);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int total;
    repeat (3) @(negedge tck);
    #1;
    check(cs_n === 1'b1 && sck === 1'b0 && mosi === 1'b0 && tdo === 1'b0, "R10 reset state",
          {60'd0, cs_n, sck, mosi, tdo}, 64'h8);
    rst_n = 1'b1;

    // table of vectors
    for (int v = 0; v < NV; v++)
      full_frame(int'(VEC[v][43:40]), int'(VEC[v][39:32]), VEC[v][31:0], $sformatf("vec%0d", v));

    // R9: the 32-clock 0x9F read of vec0 carries the full ID; recheck explicitly
    begin
      logic [23:0] id;
      clear_flash();
      total = build(0, 32'd32, 32'h9F00_0000);
      run_shift(total);
      id = '0;
      for (int j = 8; j < 32; j++) id = {id[22:0], cap[33 + 2 + j]};
      check(id == FLASH_ID, "R9 identification bytes", 64'(id), 64'(FLASH_ID));
    end

    // R1: zeros only
    clear_flash();
    fb = '0;
    run_shift(40);
    check(cs_falls == 0 && fl_cnt == 0 && stray == 0, "R1 zeros ignored", 64'(cs_falls + fl_cnt + stray), 64'd0);

    // R7: count of zero
    clear_flash();
    total = build(2, 32'd0, 32'h0);
    run_shift(total + 6);
    check(cs_falls == 0 && stray == 0, "R7 zero count no cs", 64'(cs_falls + stray), 64'd0);
    check(cs_n === 1'b1, "R7 cs_n high", {63'd0, cs_n}, 64'd1);

    // R8: abort after 10 payload bits by dropping shift
    clear_flash();
    total = build(1, 32'd32, 32'h9F00_0000);
    run_shift(1 + 33 + 10);
    check(fl_cnt == 10, "R8 abort pulse count", 64'(fl_cnt), 64'd10);
    check(cs_n === 1'b1 && stray == 0, "R8 cs released on abort", {62'd0, cs_n, 1'b0}, 64'd2);

    // R8: abort by capture pulse during payload
    clear_flash();
    total = build(0, 32'd32, 32'h9F00_0000);
    cap = '0;
    @(negedge tck); #1 sel = 1'b1; shift = 1'b1; tdi = fb[0];
    for (int k = 0; k < 33 + 5; k++) begin
      @(posedge tck);
      @(negedge tck); #1 tdi = fb[k + 1];
    end
    shift = 1'b0; capture = 1'b1;
    @(posedge tck); #1;
    @(negedge tck); #1 capture = 1'b0; sel = 1'b0;
    @(posedge tck); #1;
    check(cs_n === 1'b1 && fl_cnt == 5, "R8 capture aborts", 64'(fl_cnt), 64'd5);

    // R8: recovery after abort
    full_frame(0, 32, 32'h9F00_0000, "R8 recovery");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule